// File: doc/BRIEF.md
# Four-Channel Fly-By Transfer Sequencer

This block sequences single-item transfers between I/O devices and memory for four channels, without the data ever passing through it. A device asks for service on its request line. The sequencer picks the highest-priority eligible channel and asks the host for the bus. Once the host hands the bus over, it drives the memory address, a matched pair of memory and I/O strobes, and the channel's acknowledge. The device and the memory exchange the item directly on the data lines.

Each channel holds a programmed base address and count. It also holds a working copy of both, and the working copy steps after every item. A channel runs in one of four service styles:

- one item per bus tenure;
- a burst that runs to the end once acknowledged;
- a burst that pauses whenever the device stops asking;
- a pass-through grant in which the device drives the bus itself.

Any of the three transferring styles may also be set to reload its working address and count when the count runs out.

Programming is done by a neighbouring block through a load strobe per channel, which writes one shared set of configuration fields. Masking uses separate per-channel set and clear strobes. No data stream crosses this block, so it has no valid/ready interface. All pins are plain control and status levels sampled on the rising clock edge.

Top module: `dma_flyby`

## Requirements
- R1: After reset, hrq, dack, bus_oe, eop, all four strobes and tc_flag are 0, and every channel is masked.
- R2: A channel is eligible only while its drq is 1 and it is unmasked. A masked channel's drq causes no bus request. Among eligible channels the lowest index wins, and the choice is made only while the sequencer is idle.
- R3: hrq rises the cycle after an eligible request is seen. bus_oe stays 0 until hlda is 1. At the end of a tenure bus_oe falls at least one cycle before hrq falls.
- R4: With cfg_dir=0 (device to memory) a transfer drives mem_wr and io_rd. With cfg_dir=1 it drives mem_rd and io_wr. The strobes last one cycle plus every further cycle in which ready is 0, with the address held steady.
- R5: Each item uses the channel's working address, which then increments by one modulo 2^AW. A programmed count of N-1 moves exactly N items.
- R6: eop is 1 together with the active dack during the strobes of the item taken while the working count is 0.
- R7: Single style (cfg_mode=0) gives up the bus after every item and requests it again for the next.
- R8: Block style (cfg_mode=1) keeps the bus until the count is exhausted, even if drq falls after dack.
- R9: Demand style (cfg_mode=2) ends the tenure after an item whose strobe cycle sees drq at 0. It keeps its working address and count, and it resumes at the next address when drq returns.
- R10: Cascade style (cfg_mode=3) asserts only the channel's dack after the grant, with bus_oe and all strobes at 0. It holds the grant until that channel's drq falls.
- R11: With cfg_auto=1, the last item reloads the working address and count from the base values. The channel stays unmasked and tc_flag stays 0.
- R12: With cfg_auto=0, the last item sets the channel's mask and its tc_flag bit. A cfg_wr to that channel clears its tc_flag bit.
- R13: At most one dack bit is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| drq | input | NCH | Per-channel service request |
| dack | output | NCH | Per-channel acknowledge, at most one set |
| hrq | output | 1 | Bus request to the host |
| hlda | input | 1 | Bus granted by the host |
| ready | input | 1 | 0 stretches the current strobe cycle |
| bus_oe | output | 1 | Address and strobe drive enable; outputs read 0 while low |
| addr | output | AW | Transfer address |
| mem_rd | output | 1 | Memory read strobe (active high) |
| mem_wr | output | 1 | Memory write strobe (active high) |
| io_rd | output | 1 | Device read strobe (active high) |
| io_wr | output | 1 | Device write strobe (active high) |
| eop | output | 1 | Last item of the programmed count |
| cfg_wr | input | NCH | Per-channel load of the shared configuration fields |
| cfg_addr | input | AW | Base address to load |
| cfg_cnt | input | CW | Item count minus one to load |
| cfg_mode | input | 2 | 0 single, 1 block, 2 demand, 3 cascade |
| cfg_auto | input | 1 | Reload on terminal count |
| cfg_dir | input | 1 | 0 device to memory, 1 memory to device |
| mask_set | input | NCH | Per-channel mask set strobe |
| mask_clr | input | NCH | Per-channel mask clear strobe |
| tc_flag | output | NCH | Latched terminal-count status |

## Verification
The last item of a channel can land in the same edge as a fresh arbitration on that channel. The automatic mask is set at that edge while the channel's drq is still high. The bench provokes this by holding drq high through and past the final transfer of every table vector. It judges the result at the ports: no further transfer appears, hrq stays low, and the bus-request count and tc_flag keep their expected values. A second collision, terminal count against the demand-style drq check, is covered by the reload and suspension tests. Those tests compare the address of the first item after resumption with the expected address.

// File: rtl/dma_flyby_pkg.sv
package dma_flyby_pkg;
  typedef enum logic [1:0] {
    XM_SINGLE  = 2'd0,
    XM_BLOCK   = 2'd1,
    XM_DEMAND  = 2'd2,
    XM_CASCADE = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HOLD,
    SQ_ADDR,
    SQ_STRB,
    SQ_CASC,
    SQ_ENDS
  } seq_state_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_flyby_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_cnt,
  input  xfer_mode_e    cfg_mode,
  input  logic          cfg_auto,
  input  logic          cfg_dir,
  input  logic          mask_set,
  input  logic          mask_clr,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output xfer_mode_e    mode,
  output logic          dir,
  output logic          masked,
  output logic          at_tc,
  output logic          tc_flag
);
  logic [AW-1:0] base_addr;
  logic [CW-1:0] base_cnt;
  logic [CW-1:0] cur_cnt;
  logic          auto_en;
  logic          finish;

  assign at_tc  = (cur_cnt == '0);
  assign finish = step && at_tc;

  // working copy, base copy and latched status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= XM_SINGLE;
      auto_en   <= 1'b0;
      dir       <= 1'b0;
      tc_flag   <= 1'b0;
    end else if (cfg_wr) begin
      base_addr <= cfg_addr;
      base_cnt  <= cfg_cnt;
      cur_addr  <= cfg_addr;
      cur_cnt   <= cfg_cnt;
      mode      <= cfg_mode;
      auto_en   <= cfg_auto;
      dir       <= cfg_dir;
      tc_flag   <= 1'b0;
    end else if (step) begin
      if (finish && auto_en) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= cur_addr + AW'(1);
        cur_cnt  <= cur_cnt - CW'(1);
        if (finish) tc_flag <= 1'b1;
      end
    end
  end

  // mask: clear, then explicit set, then automatic set at terminal count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      masked <= 1'b1;
    end else begin
      if (mask_clr) masked <= 1'b0;
      if (mask_set) masked <= 1'b1;
      if (finish && !auto_en) masked <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0]         req,
  output logic                   any,
  output logic [$clog2(NCH)-1:0] idx
);
  localparam int IW = $clog2(NCH);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_flyby_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   any_req,
  input  logic [$clog2(NCH)-1:0] req_idx,
  input  xfer_mode_e             act_mode,
  input  logic                   act_tc,
  input  logic                   act_drq,
  input  logic                   hlda,
  input  logic                   ready,
  output logic [$clog2(NCH)-1:0] act_idx,
  output logic                   hrq,
  output logic                   bus_oe,
  output logic                   dack_on,
  output logic                   strobe,
  output logic                   eop,
  output logic                   step
);
  seq_state_e state, nxt;

  always_comb begin
    nxt  = state;
    step = 1'b0;
    case (state)
      SQ_IDLE: if (any_req) nxt = SQ_HOLD;
      SQ_HOLD: if (hlda) nxt = (act_mode == XM_CASCADE) ? SQ_CASC : SQ_ADDR;
      SQ_ADDR: nxt = SQ_STRB;
      SQ_STRB: begin
        if (ready) begin
          step = 1'b1;
          if (act_tc || act_mode == XM_SINGLE ||
              (act_mode == XM_DEMAND && !act_drq))
            nxt = SQ_ENDS;
          else
            nxt = SQ_ADDR;
        end
      end
      SQ_CASC: if (!act_drq) nxt = SQ_ENDS;
      SQ_ENDS: nxt = SQ_IDLE;
      default: nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      act_idx <= '0;
    end else begin
      state <= nxt;
      if (state == SQ_IDLE && any_req) act_idx <= req_idx;
    end
  end

  assign hrq     = (state != SQ_IDLE);
  assign bus_oe  = (state == SQ_ADDR) || (state == SQ_STRB);
  assign dack_on = bus_oe || (state == SQ_CASC);
  assign strobe  = (state == SQ_STRB);
  assign eop     = strobe && act_tc;
endmodule

// File: rtl/dma_flyby.sv
module dma_flyby
  import dma_flyby_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] drq,
  output logic [NCH-1:0] dack,
  output logic           hrq,
  input  logic           hlda,
  input  logic           ready,
  output logic           bus_oe,
  output logic [AW-1:0]  addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic           eop,
  input  logic [NCH-1:0] cfg_wr,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_cnt,
  input  logic [1:0]     cfg_mode,
  input  logic           cfg_auto,
  input  logic           cfg_dir,
  input  logic [NCH-1:0] mask_set,
  input  logic [NCH-1:0] mask_clr,
  output logic [NCH-1:0] tc_flag
);
  localparam int IW = $clog2(NCH);

  logic [AW-1:0]  ch_addr [NCH];
  xfer_mode_e     ch_mode [NCH];
  logic [NCH-1:0] ch_dir;
  logic [NCH-1:0] ch_masked;
  logic [NCH-1:0] ch_tc;
  logic [NCH-1:0] eligible;

  logic          any_req;
  logic [IW-1:0] req_idx;
  logic [IW-1:0] act_idx;
  logic          dack_on;
  logic          strobe;
  logic          step;
  logic          act_dir;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr[g]),
        .cfg_addr (cfg_addr),
        .cfg_cnt  (cfg_cnt),
        .cfg_mode (xfer_mode_e'(cfg_mode)),
        .cfg_auto (cfg_auto),
        .cfg_dir  (cfg_dir),
        .mask_set (mask_set[g]),
        .mask_clr (mask_clr[g]),
        .step     (step && (act_idx == IW'(g))),
        .cur_addr (ch_addr[g]),
        .mode     (ch_mode[g]),
        .dir      (ch_dir[g]),
        .masked   (ch_masked[g]),
        .at_tc    (ch_tc[g]),
        .tc_flag  (tc_flag[g])
      );
      assign eligible[g] = drq[g] && !ch_masked[g];
    end
  endgenerate

  dma_prio_arb #(.NCH(NCH)) u_arb (
    .req (eligible),
    .any (any_req),
    .idx (req_idx)
  );

  dma_seq #(.NCH(NCH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_req  (any_req),
    .req_idx  (req_idx),
    .act_mode (ch_mode[act_idx]),
    .act_tc   (ch_tc[act_idx]),
    .act_drq  (drq[act_idx]),
    .hlda     (hlda),
    .ready    (ready),
    .act_idx  (act_idx),
    .hrq      (hrq),
    .bus_oe   (bus_oe),
    .dack_on  (dack_on),
    .strobe   (strobe),
    .eop      (eop),
    .step     (step)
  );

  assign act_dir = ch_dir[act_idx];
  assign addr    = bus_oe ? ch_addr[act_idx] : '0;
  assign mem_wr  = strobe && !act_dir;
  assign io_rd   = strobe && !act_dir;
  assign mem_rd  = strobe && act_dir;
  assign io_wr   = strobe && act_dir;
  assign dack    = dack_on ? (NCH'(1) << act_idx) : '0;
endmodule

// File: rtl/dma_flyby_chk.sv
module dma_flyby_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dack,
  input logic           hrq,
  input logic           hlda,
  input logic           ready,
  input logic           bus_oe,
  input logic [AW-1:0]  addr,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           io_rd,
  input logic           io_wr,
  input logic           eop
);
  logic strb_any;
  assign strb_any = mem_rd || mem_wr;

  p_dack_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  p_oe_needs_hlda_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> hlda);

  p_release_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hrq && $past(hrq)) |-> !$past(bus_oe));

  p_dack_needs_hrq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |-> hrq);

  p_strobe_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr) |->
      (mem_wr == io_rd) && (mem_rd == io_wr) && !(mem_wr && mem_rd) && bus_oe);

  p_strobe_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_any && !ready) |=> (strb_any && $stable(addr)));

  p_eop_with_dack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> (strb_any && (dack != '0)));
endmodule

bind dma_flyby dma_flyby_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .dack   (dack),
  .hrq    (hrq),
  .hlda   (hlda),
  .ready  (ready),
  .bus_oe (bus_oe),
  .addr   (addr),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .io_rd  (io_rd),
  .io_wr  (io_wr),
  .eop    (eop)
);

// File: tb/dma_flyby_tb_top.sv
module dma_flyby_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int CW  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic [NCH-1:0] drq;
  logic [NCH-1:0] dack;
  logic           hrq;
  logic           hlda;
  logic           ready;
  logic           bus_oe;
  logic [AW-1:0]  addr;
  logic           mem_rd, mem_wr, io_rd, io_wr, eop;
  logic [NCH-1:0] cfg_wr;
  logic [AW-1:0]  cfg_addr;
  logic [CW-1:0]  cfg_cnt;
  logic [1:0]     cfg_mode;
  logic           cfg_auto, cfg_dir;
  logic [NCH-1:0] mask_set, mask_clr;
  logic [NCH-1:0] tc_flag;

  dma_flyby #(.NCH(NCH), .AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .drq(drq), .dack(dack), .hrq(hrq), .hlda(hlda),
    .ready(ready), .bus_oe(bus_oe), .addr(addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .eop(eop),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt),
    .cfg_mode(cfg_mode), .cfg_auto(cfg_auto), .cfg_dir(cfg_dir),
    .mask_set(mask_set), .mask_clr(mask_clr), .tc_flag(tc_flag)
  );

  // host model: grant follows request a fraction of a cycle later
  initial begin
    hlda = 1'b0;
    forever begin
      @(posedge clk);
      #3;
      hlda = hrq;
    end
  end

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  mode;
    logic        dir;
    logic        pulse;
    logic [15:0] base;
    logic [15:0] cnt;
    logic [7:0]  grants;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{ch:2'd0, mode:2'd0, dir:1'b0, pulse:1'b0, base:16'h1000, cnt:16'd2, grants:8'd3},
    '{ch:2'd1, mode:2'd1, dir:1'b1, pulse:1'b0, base:16'h20FE, cnt:16'd3, grants:8'd1},
    '{ch:2'd2, mode:2'd2, dir:1'b0, pulse:1'b0, base:16'hFFFE, cnt:16'd3, grants:8'd1},
    '{ch:2'd3, mode:2'd1, dir:1'b0, pulse:1'b1, base:16'h0400, cnt:16'd4, grants:8'd1},
    '{ch:2'd0, mode:2'd0, dir:1'b1, pulse:1'b0, base:16'h0ABC, cnt:16'd0, grants:8'd1},
    '{ch:2'd1, mode:2'd2, dir:1'b1, pulse:1'b0, base:16'h3000, cnt:16'd7, grants:8'd1}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // port monitor, sampled on the falling edge
  int          m_xfer, m_grants, m_eop, m_strobe_err, m_proto_err, m_gap_err, m_strb_cyc;
  logic [15:0] m_first, m_last, m_eop_addr;
  logic [3:0]  m_first_dack;
  logic        exp_dir;
  logic        prev_hrq = 1'b0, prev_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd || mem_wr || io_rd || io_wr) begin
        m_strb_cyc++;
        if (exp_dir ? !(mem_rd && io_wr && !mem_wr && !io_rd)
                    : !(mem_wr && io_rd && !mem_rd && !io_wr))
          m_strobe_err++;
        if (ready) begin
          if (m_xfer == 0) begin
            m_first      = addr;
            m_first_dack = dack;
          end else if (addr != 16'(m_last + 16'd1)) begin
            m_gap_err++;
          end
          m_last = addr;
          m_xfer++;
          if (eop) begin
            m_eop++;
            m_eop_addr = addr;
          end
        end
      end
      if (hrq && !prev_hrq) m_grants++;
      if (bus_oe && !hlda) m_proto_err++;
      if (prev_hrq && !hrq && prev_oe) m_proto_err++;
      if ($countones(dack) > 1) m_proto_err++;
      if (eop && dack == '0) m_proto_err++;
    end
    prev_hrq = hrq;
    prev_oe  = bus_oe;
  end

  task automatic clear_mon();
    m_xfer = 0; m_grants = 0; m_eop = 0; m_strobe_err = 0;
    m_proto_err = 0; m_gap_err = 0; m_strb_cyc = 0;
    m_first = '0; m_last = '0; m_eop_addr = '0; m_first_dack = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic program_ch(input int ch, input logic [1:0] mode, input logic auto_en,
                            input logic dir, input logic [15:0] base, input logic [15:0] cnt);
    cfg_addr = base;
    cfg_cnt  = cnt;
    cfg_mode = mode;
    cfg_auto = auto_en;
    cfg_dir  = dir;
    cfg_wr   = 4'(1 << ch);
    exp_dir  = dir;
    step();
    cfg_wr = '0;
  endtask

  task automatic unmask(input int ch);
    mask_clr = 4'(1 << ch);
    step();
    mask_clr = '0;
  endtask

  task automatic wait_tc(input int ch);
    for (int t = 0; t < 3000 && !tc_flag[ch]; t++) step();
  endtask

  task automatic wait_eop();
    for (int t = 0; t < 3000 && m_eop == 0; t++) step();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; drq = '0; ready = 1'b1;
    cfg_wr = '0; cfg_addr = '0; cfg_cnt = '0; cfg_mode = '0;
    cfg_auto = 1'b0; cfg_dir = 1'b0; mask_set = '0; mask_clr = '0;
    exp_dir = 1'b0;
    clear_mon();
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(hrq == 1'b0 && dack == '0 && bus_oe == 1'b0 && eop == 1'b0, "R1 idle outputs",
        int'({hrq, dack, bus_oe, eop}), 0);
    chk({mem_rd, mem_wr, io_rd, io_wr} == '0 && tc_flag == '0, "R1 strobes/flags",
        int'({mem_rd, mem_wr, io_rd, io_wr, tc_flag}), 0);

    // R2 masked after reset: request ignored
    program_ch(0, 2'd0, 1'b0, 1'b0, 16'h0010, 16'd0);
    clear_mon();
    drq[0] = 1'b1;
    repeat (12) step();
    chk(m_grants == 0 && hrq == 1'b0, "R2 masked drq ignored", m_grants, 0);
    drq[0] = 1'b0;
    step();

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      int ch;
      logic [15:0] exp_last;
      ch = int'(VEC[v].ch);
      exp_last = 16'(VEC[v].base + VEC[v].cnt);
      program_ch(ch, VEC[v].mode, 1'b0, VEC[v].dir, VEC[v].base, VEC[v].cnt);
      unmask(ch);
      clear_mon();
      drq[ch] = 1'b1;
      for (int t = 0; t < 3000 && !tc_flag[ch]; t++) begin
        step();
        if (VEC[v].pulse && dack[ch]) drq[ch] = 1'b0;
      end
      repeat (8) step();  // drq still high unless pulsed: channel must be masked now
      chk(m_xfer == int'(VEC[v].cnt) + 1, "R5 item count", m_xfer, int'(VEC[v].cnt) + 1);
      chk(m_first == VEC[v].base, "R5 first address", int'(m_first), int'(VEC[v].base));
      chk(m_last == exp_last && m_gap_err == 0, "R5 last address/step",
          int'(m_last), int'(exp_last));
      chk(m_eop == 1 && m_eop_addr == exp_last, "R6 eop on last item", m_eop, 1);
      chk(m_grants == int'(VEC[v].grants), "R7 R8 R9 bus tenures", m_grants,
          int'(VEC[v].grants));
      chk(m_strobe_err == 0, "R4 strobe pair", m_strobe_err, 0);
      chk(m_proto_err == 0, "R3 R13 bus protocol", m_proto_err, 0);
      chk(tc_flag[ch] == 1'b1 && hrq == 1'b0, "R12 tc flag and auto mask",
          int'({tc_flag[ch], hrq}), 2);
      drq[ch] = 1'b0;
      step();
    end

    // R2 priority: channel 1 beats channel 2
    program_ch(2, 2'd0, 1'b0, 1'b0, 16'h0200, 16'd0);
    unmask(2);
    program_ch(1, 2'd0, 1'b0, 1'b0, 16'h0100, 16'd0);
    chk(tc_flag[1] == 1'b0, "R12 cfg_wr clears tc flag", int'(tc_flag[1]), 0);
    unmask(1);
    clear_mon();
    drq[2:1] = 2'b11;
    wait_tc(2);
    wait_tc(1);
    drq = '0;
    step();
    chk(m_first_dack == 4'b0010 && m_first == 16'h0100, "R2 fixed priority",
        int'(m_first_dack), 2);
    chk(m_xfer == 2, "R2 both served", m_xfer, 2);

    // R4 ready wait: strobes stretch
    program_ch(0, 2'd0, 1'b0, 1'b0, 16'h0700, 16'd0);
    unmask(0);
    clear_mon();
    ready = 1'b0;
    drq[0] = 1'b1;
    for (int t = 0; t < 200 && m_strb_cyc == 0; t++) step();
    step();
    step();
    ready = 1'b1;
    wait_tc(0);
    drq[0] = 1'b0;
    step();
    chk(m_strb_cyc == 4 && m_xfer == 1, "R4 ready stretch", m_strb_cyc, 4);
    chk(m_first == 16'h0700, "R4 address during wait", int'(m_first), 16'h0700);

    // R9 demand suspend and resume
    program_ch(3, 2'd2, 1'b0, 1'b1, 16'h0500, 16'd5);
    unmask(3);
    clear_mon();
    drq[3] = 1'b1;
    for (int t = 0; t < 200 && m_xfer < 2; t++) step();
    drq[3] = 1'b0;
    repeat (6) step();
    chk(m_xfer == 3 && hrq == 1'b0, "R9 suspend after drq drop", m_xfer, 3);
    drq[3] = 1'b1;
    wait_tc(3);
    drq[3] = 1'b0;
    step();
    chk(m_xfer == 6 && m_gap_err == 0 && m_last == 16'h0505, "R9 resume in place",
        int'(m_last), 16'h0505);
    chk(m_grants == 2, "R9 two tenures", m_grants, 2);

    // R10 cascade
    begin
      int bad;
      bad = 0;
      program_ch(3, 2'd3, 1'b0, 1'b0, 16'h0000, 16'd0);
      unmask(3);
      clear_mon();
      drq[3] = 1'b1;
      for (int t = 0; t < 200 && !dack[3]; t++) step();
      for (int t = 0; t < 6; t++) begin
        if (dack != 4'b1000 || bus_oe || mem_rd || mem_wr || io_rd || io_wr) bad++;
        step();
      end
      drq[3] = 1'b0;
      repeat (3) step();
      chk(bad == 0, "R10 cascade drives only dack", bad, 0);
      chk(dack == '0 && hrq == 1'b0 && m_xfer == 0, "R10 cascade release",
          int'({dack, hrq}), 0);
    end

    // R11 autoinitialize reload
    program_ch(2, 2'd1, 1'b1, 1'b0, 16'h0100, 16'd2);
    unmask(2);
    clear_mon();
    drq[2] = 1'b1;
    wait_eop();
    drq[2] = 1'b0;
    repeat (3) step();
    chk(m_xfer == 3 && tc_flag[2] == 1'b0, "R11 no tc flag in reload", m_xfer, 3);
    clear_mon();
    drq[2] = 1'b1;
    wait_eop();
    drq[2] = 1'b0;
    repeat (3) step();
    chk(m_first == 16'h0100 && m_xfer == 3, "R11 reloaded address and count",
        int'(m_first), 16'h0100);
    chk(m_proto_err == 0, "R13 dack exclusive", m_proto_err, 0);

    summary();
    $finish;
  end
endmodule